// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the power-saving states of a small microcontroller core. The instruction decoder sends a one-cycle request to enter a light sleep (idle) or a deep sleep (stop). In return the block drives three enables: one for the CPU clock, one for the main oscillator and one for the peripherals. It also reports its current state on a 2-bit code. When any interrupt source has both its request bit and its enable bit set, the core wakes. After a deep sleep, and after every reset, the oscillator is given a fixed settling interval before the CPU clock runs again.

On a wake, the block emits a one-cycle resume strobe. It then chooses between two outcomes. On a plain resume, execution simply continues. On a vectored wake, the block waits for the core to retire exactly two instructions and then raises a vectored-interrupt request for one cycle. The vectored outcome is taken only when the master interrupt enable is set and at least one waking source lies outside a designated set of two sources. The designated sources, a timer source and an external-interrupt source, always resume plainly.

Top module: `pmc_top`

## Requirements
- R1: An active-low reset, asynchronous to the clock, forces `mode` to 3 (settling) with `cpu_clk_en`=0, `osc_en`=1 and `periph_en`=1. After reset is released, `mode` turns to 0 (run) with `cpu_clk_en`=1 on exactly the SETTLE_CYCLES-th rising edge. No resume strobe and no vector request follow a reset.
- R2: In run, an `idle_req` pulse moves the block to `mode`=1. In that mode `cpu_clk_en`=0 while `osc_en` and `periph_en` stay 1.
- R3: In run, a `stop_req` pulse moves the block to `mode`=2. In that mode `cpu_clk_en`, `osc_en` and `periph_en` are all 0. When both requests arrive in the same cycle, stop wins.
- R4: Idle is left on the first edge that sees some source i with `irq_pend[i]`=1 and `irq_en[i]`=1. The block enters run, and `resume_pulse` is 1 for that first run cycle only. A source with only one of its two bits set does not wake the block.
- R5: Stop is left on the same wake condition, into `mode`=3 with `osc_en`=1, `periph_en`=1 and `cpu_clk_en`=0. Run follows on the SETTLE_CYCLES-th edge after the wake edge, and `resume_pulse` is 1 in that first run cycle.
- R6: If a waking source is already pending when idle is entered, the block spends exactly one cycle in idle.
- R7: A wake with `master_ie`=0 never produces `vec_req`.
- R8: A wake with `master_ie`=1 and at least one waking source outside the designated set raises `vec_req` for one cycle. It appears in the cycle right after the edge that sees the second `instr_retired` strobe in run.
- R9: Sources PLAIN_SRC_A and PLAIN_SRC_B (defaults 2 and 3) wake with a plain resume and no `vec_req`, whatever `master_ie` is.
- R10: While a vector request is still pending, up to and including the cycle in which `vec_req` is 1, idle and stop requests in run are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_req | input | 1 | Decoder pulse: enter idle |
| stop_req | input | 1 | Decoder pulse: enter stop |
| irq_pend | input | NSRC | Per-source interrupt request bits |
| irq_en | input | NSRC | Per-source interrupt enable bits |
| master_ie | input | 1 | Master interrupt enable |
| instr_retired | input | 1 | One pulse per retired instruction |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Main oscillator enable |
| periph_en | output | 1 | Peripheral enable |
| resume_pulse | output | 1 | One-cycle strobe on wake-up |
| vec_req | output | 1 | Deferred vectored-interrupt request |
| mode | output | 2 | 0 run, 1 idle, 2 stop, 3 settling |

## Verification
The assertions check the following on every cycle: the idle exit on a live wake condition, that stop never reaches run except through settling, that settling is held until the timer finishes, that the vector pulse lasts one cycle and follows a retire strobe, and that run is held while a vector is pending. Only the bench scenarios can show the settling length counted from reset and from a stop wake, the choice between plain and vectored wake for each source and each master-enable value, and the immediate release. They also cover the sources that have only one of their two bits set, and the recovery from a reset that arrives during stop.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    PM_RUN    = 2'd0,
    PM_IDLE   = 2'd1,
    PM_STOP   = 2'd2,
    PM_SETTLE = 2'd3
  } pm_state_e;

  localparam int PMC_MAX_SRC = 32;

  // Enabled-and-pending set of sources.
  function automatic logic [PMC_MAX_SRC-1:0] live_sources(
      input logic [PMC_MAX_SRC-1:0] pend,
      input logic [PMC_MAX_SRC-1:0] en);
    return pend & en;
  endfunction

  // A wake is vectored when interrupts are globally enabled and a
  // waking source lies outside the plain-resume set.
  function automatic logic wants_vector(
      input logic [PMC_MAX_SRC-1:0] live,
      input logic [PMC_MAX_SRC-1:0] plain,
      input logic                   mie);
    return mie && ((live & ~plain) != '0);
  endfunction

endpackage

// File: rtl/pmc_wake_eval.sv
module pmc_wake_eval
  import pmc_pkg::*;
#(
  parameter int NSRC        = 8,
  parameter int PLAIN_SRC_A = 2,
  parameter int PLAIN_SRC_B = 3
) (
  input  logic [NSRC-1:0] irq_pend,
  input  logic [NSRC-1:0] irq_en,
  input  logic            master_ie,
  output logic            wake,
  output logic            route_vec
);

  localparam logic [PMC_MAX_SRC-1:0] PLAIN_MASK =
    (PMC_MAX_SRC'(1) << PLAIN_SRC_A) | (PMC_MAX_SRC'(1) << PLAIN_SRC_B);

  logic [PMC_MAX_SRC-1:0] pend_w;
  logic [PMC_MAX_SRC-1:0] en_w;
  logic [PMC_MAX_SRC-1:0] live;

  always_comb begin
    pend_w = '0;
    en_w   = '0;
    pend_w[NSRC-1:0] = irq_pend;
    en_w[NSRC-1:0]   = irq_en;
    live      = live_sources(pend_w, en_w);
    wake      = (live != '0);
    route_vec = wants_vector(live, PLAIN_MASK, master_ie);
  end

endmodule

// File: rtl/pmc_settle_timer.sv
module pmc_settle_timer #(
  parameter int SETTLE_CYCLES = 131072
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  output logic done
);

  localparam int CW = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done = run_en && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run_en || done) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  AST_SETTLE_NOT_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (cnt_q == '0)) else $error("settle count moved while unused"); // R5

endmodule

// File: rtl/pmc_vec_seq.sv
module pmc_vec_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic retire,
  output logic vec_req,
  output logic busy
);

  logic armed_q;
  logic seen_q;
  logic vec_q;

  assign vec_req = vec_q;
  assign busy    = armed_q | vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      seen_q  <= 1'b0;
      vec_q   <= 1'b0;
    end else begin
      vec_q <= 1'b0;
      if (arm) begin
        armed_q <= 1'b1;
        seen_q  <= 1'b0;
      end else if (armed_q && retire) begin
        if (seen_q) begin
          vec_q   <= 1'b1;
          armed_q <= 1'b0;
          seen_q  <= 1'b0;
        end else begin
          seen_q <= 1'b1;
        end
      end
    end
  end

  AST_VEC_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_q |=> !vec_q) else $error("vector pulse longer than one cycle"); // R8
  AST_VEC_AFTER_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_q) |-> ($past(retire) && $past(armed_q))) else $error("vector without retire"); // R8

endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
#(
  parameter int NSRC          = 8,
  parameter int SETTLE_CYCLES = 131072,
  parameter int PLAIN_SRC_A   = 2,
  parameter int PLAIN_SRC_B   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle_req,
  input  logic            stop_req,
  input  logic [NSRC-1:0] irq_pend,
  input  logic [NSRC-1:0] irq_en,
  input  logic            master_ie,
  input  logic            instr_retired,
  output logic            cpu_clk_en,
  output logic            osc_en,
  output logic            periph_en,
  output logic            resume_pulse,
  output logic            vec_req,
  output logic [1:0]      mode
);

  pm_state_e state_q, state_d;
  logic      stop_woke_q, stop_woke_d;
  logic      route_q, route_d;
  logic      resume_q, resume_d;
  logic      arm_vec;

  // named internal events
  logic wake;
  logic route_vec;
  logic settle_done;
  logic vec_busy;
  logic in_settle;
  logic retire_run;

  assign in_settle  = (state_q == PM_SETTLE);
  assign retire_run = instr_retired && (state_q == PM_RUN);

  pmc_wake_eval #(
    .NSRC(NSRC), .PLAIN_SRC_A(PLAIN_SRC_A), .PLAIN_SRC_B(PLAIN_SRC_B)
  ) u_wake (
    .irq_pend(irq_pend), .irq_en(irq_en), .master_ie(master_ie),
    .wake(wake), .route_vec(route_vec)
  );

  pmc_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .run_en(in_settle), .done(settle_done)
  );

  pmc_vec_seq u_vec (
    .clk(clk), .rst_n(rst_n), .arm(arm_vec), .retire(retire_run),
    .vec_req(vec_req), .busy(vec_busy)
  );

  always_comb begin
    state_d     = state_q;
    stop_woke_d = stop_woke_q;
    route_d     = route_q;
    resume_d    = 1'b0;
    arm_vec     = 1'b0;
    unique case (state_q)
      PM_RUN: begin
        if (!vec_busy && stop_req)      state_d = PM_STOP;
        else if (!vec_busy && idle_req) state_d = PM_IDLE;
      end
      PM_IDLE: begin
        if (wake) begin
          state_d  = PM_RUN;
          resume_d = 1'b1;
          arm_vec  = route_vec;
        end
      end
      PM_STOP: begin
        if (wake) begin
          state_d     = PM_SETTLE;
          stop_woke_d = 1'b1;
          route_d     = route_vec;
        end
      end
      PM_SETTLE: begin
        if (settle_done) begin
          state_d     = PM_RUN;
          resume_d    = stop_woke_q;
          arm_vec     = stop_woke_q && route_q;
          stop_woke_d = 1'b0;
          route_d     = 1'b0;
        end
      end
      default: state_d = PM_SETTLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PM_SETTLE;
      stop_woke_q <= 1'b0;
      route_q     <= 1'b0;
      resume_q    <= 1'b0;
    end else begin
      state_q     <= state_d;
      stop_woke_q <= stop_woke_d;
      route_q     <= route_d;
      resume_q    <= resume_d;
    end
  end

  assign mode         = state_q;
  assign cpu_clk_en   = (state_q == PM_RUN);
  assign osc_en       = (state_q != PM_STOP);
  assign periph_en    = (state_q != PM_STOP);
  assign resume_pulse = resume_q;

  AST_IDLE_WAKE_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_IDLE && wake) |=> (state_q == PM_RUN && resume_pulse)) else $error("idle wake missed"); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_IDLE && !wake) |=> (state_q == PM_IDLE)) else $error("idle left without wake"); // R4
  AST_STOP_VIA_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_STOP) |=> (state_q == PM_STOP || state_q == PM_SETTLE)) else $error("stop skipped settling"); // R5
  AST_SETTLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_SETTLE && !settle_done) |=> (state_q == PM_SETTLE)) else $error("settling cut short"); // R5
  AST_BUSY_BLOCKS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_RUN && vec_busy) |=> (state_q == PM_RUN)) else $error("sleep entered with vector pending"); // R10
  AST_RESUME_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |-> (cpu_clk_en && $past(state_q) != PM_RUN)) else $error("resume outside wake"); // R4

endmodule

// File: tb/pmc_top_bench.sv
`timescale 1ns/1ps
module pmc_top_bench;

  localparam int NSRC   = 4;
  localparam int SETTLE = 8;
  localparam int PA     = 2;
  localparam int PB     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle_req = 1'b0, stop_req = 1'b0, master_ie = 1'b0, instr_retired = 1'b0;
  logic [NSRC-1:0] irq_pend = '0, irq_en = '0;
  logic cpu_clk_en, osc_en, periph_en, resume_pulse, vec_req;
  logic [1:0] mode;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  pmc_top #(.NSRC(NSRC), .SETTLE_CYCLES(SETTLE), .PLAIN_SRC_A(PA), .PLAIN_SRC_B(PB)) u_pmc_top (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .stop_req(stop_req),
    .irq_pend(irq_pend), .irq_en(irq_en), .master_ie(master_ie),
    .instr_retired(instr_retired), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
    .periph_en(periph_en), .resume_pulse(resume_pulse), .vec_req(vec_req), .mode(mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // packed enables: {cpu, osc, periph}
  function automatic int en3(input int m);
    case (m)
      0: return 3'b111;
      1: return 3'b011;
      2: return 3'b000;
      default: return 3'b011;
    endcase
  endfunction

  task automatic chk_mode(input string req, input int m);
    chk(req, mode, m);
    chk(req, {cpu_clk_en, osc_en, periph_en}, en3(m));
  endtask

  function automatic bit expect_vec(input logic [NSRC-1:0] live, input bit mie);
    logic [NSRC-1:0] plain;
    plain = '0;
    plain[PA] = 1'b1;
    plain[PB] = 1'b1;
    return mie && ((live & ~plain) != '0);
  endfunction

  // After resume: retire twice and look for the vector pulse.
  task automatic retire_and_check(input bit exp_vec, input bit probe_block);
    if (probe_block) begin
      idle_req = 1'b1; stop_req = 1'b1;
      tick();
      idle_req = 1'b0; stop_req = 1'b0;
      chk("R10 request ignored while vector pending", mode, 0);
    end
    instr_retired = 1'b1; tick(); instr_retired = 1'b0;
    chk("R8 no vector after first retire", vec_req, 0);
    tick();
    chk("R8 no vector without second retire", vec_req, 0);
    instr_retired = 1'b1;
    if (exp_vec) begin
      stop_req = 1'b1;
      tick();
      stop_req = 1'b0;
    end else begin
      tick();
    end
    instr_retired = 1'b0;
    chk(exp_vec ? "R8 vector after second retire" : "R7 R9 plain resume has no vector", vec_req, exp_vec);
    if (exp_vec) chk("R10 stop ignored on vector cycle", mode, 0);
    tick();
    chk("R8 vector lasts one cycle", vec_req, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    chk_mode("R1 settling under reset", 3);
    tick();
    rst_n = 1'b1;
    for (int k = 1; k < SETTLE; k++) begin
      tick();
      chk("R1 still settling after reset", mode, 3);
    end
    tick();
    chk_mode("R1 run after settle", 0);
    chk("R1 no resume after reset", resume_pulse, 0);
    chk("R1 no vector after reset", vec_req, 0);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    tick();
    do_reset();
    irq_en = '1;

    // sweep: every source x master enable x sleep kind
    for (int s = 0; s < NSRC; s++) begin
      for (int mie = 0; mie < 2; mie++) begin
        for (int kind = 0; kind < 2; kind++) begin
          logic [NSRC-1:0] one;
          bit ev;
          one = '0; one[s] = 1'b1;
          ev = expect_vec(one, mie[0]);
          master_ie = mie[0];
          if (kind == 0) begin
            idle_req = 1'b1; tick(); idle_req = 1'b0;
            chk_mode("R2 idle entered", 1);
            tick();
            chk("R4 idle held without wake", mode, 1);
            irq_pend = one; tick(); irq_pend = '0;
            chk_mode("R4 idle wake to run", 0);
            chk("R4 resume strobe", resume_pulse, 1);
          end else begin
            stop_req = 1'b1; tick(); stop_req = 1'b0;
            chk_mode("R3 stop entered", 2);
            tick();
            chk("R3 stop held without wake", mode, 2);
            irq_pend = one; tick(); irq_pend = '0;
            chk_mode("R5 stop wake into settling", 3);
            for (int k = 1; k < SETTLE; k++) begin
              tick();
              chk("R5 settling length", mode, 3);
            end
            tick();
            chk_mode("R5 run after stop settle", 0);
            chk("R5 resume strobe", resume_pulse, 1);
          end
          tick();
          chk("R4 resume one cycle", resume_pulse, 0);
          retire_and_check(ev, ev);
        end
      end
    end

    // R4: pend without enable, enable without pend
    master_ie = 1'b0;
    idle_req = 1'b1; tick(); idle_req = 1'b0;
    irq_en = 4'b1110; irq_pend = 4'b0001;
    tick(); tick();
    chk("R4 pending but disabled does not wake", mode, 1);
    irq_pend = 4'b0000;
    tick();
    chk("R4 enabled but not pending does not wake", mode, 1);
    irq_en = 4'b0001; irq_pend = 4'b0001;
    tick();
    chk("R4 wake once both bits set", mode, 0);
    irq_pend = '0; irq_en = '1;
    tick();

    // R6: immediate release
    irq_pend = 4'b0010;
    idle_req = 1'b1; tick(); idle_req = 1'b0;
    chk("R6 idle entered with pending source", mode, 1);
    tick();
    chk("R6 one cycle in idle", mode, 0);
    chk("R6 resume", resume_pulse, 1);
    irq_pend = '0;
    tick();

    // R9: plain source mixed with vectored source -> vectored
    master_ie = 1'b1;
    idle_req = 1'b1; tick(); idle_req = 1'b0;
    irq_pend = 4'b0101; tick(); irq_pend = '0;
    chk("R9 mixed wake resumes", mode, 0);
    retire_and_check(expect_vec(4'b0101, 1'b1), 1'b0);
    // both designated together -> plain
    idle_req = 1'b1; tick(); idle_req = 1'b0;
    irq_pend = 4'b1100; tick(); irq_pend = '0;
    retire_and_check(expect_vec(4'b1100, 1'b1), 1'b0);

    // R3: simultaneous requests, stop wins; then reset during stop
    idle_req = 1'b1; stop_req = 1'b1; tick(); idle_req = 1'b0; stop_req = 1'b0;
    chk_mode("R3 stop wins over idle", 2);
    do_reset();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule